// File: doc/BRIEF.md
# Inter-Thread Storage Controller

This block sits in front of a small bank of 64-bit storage cells that threads share for communication. The cells occupy an address window that can be moved and resized at run time. Each bus address inside the window picks a cell index and an access view. Cell views move the cell's 64-bit value. One reserved view exposes a control and status word. That word holds sticky error flags, a granularity field that sets the spacing between cells, and a read-only cell count.

A separate window register sets where the bank appears. It holds an enable bit, a log2 size and a base address. The controller checks each access. It answers with a bus error when an access falls outside the window, uses a byte or halfword size, or addresses a cell that does not exist. Every request gets exactly one response on the following cycle.

Top module: `itc_ctrl_unit`

## Requirements
- R1: After reset the control word reads NUM_CELLS shifted left by 16, with error flags and granularity zero. The window register reads 0x22, which is disabled with a size of 2^17 bytes. No response is pending.
- R2: An access hits the window only when window bit 0 is 1 and the address lies in [base, base + 2^size). Here size is window bits 5:1 and base is window bits 47:13 placed at address bit 17. Any other access gets an error response with read data 0 and changes no state.
- R3: A hitting access with size code 0 (1 byte) or 1 (2 bytes) gets an error response with read data 0. It sets control bit 2 and writes nothing else. Size code 2 means 4 bytes and size code 3 means 8 bytes.
- R4: The view code is offset bits 6:3. View 15 reads the control word.
- R5: A write to view 15 clears each flag in bits 2:0 whose data bit is 1 and loads bits 10:8 from the data. All other control bits keep their value.
- R6: The cell index is the window offset shifted right by 7 plus the granularity field in control bits 10:8.
- R7: A cell view with an index at or beyond NUM_CELLS gets an error response and changes no cell.
- R8: Views 0 to 5 read and write the addressed cell. An 8-byte access moves all 64 bits. A 4-byte write stores the low 32 data bits zero-extended, and a 4-byte read returns the low 32 bits zero-extended.
- R9: Views 6 to 14 read as all ones (low 32 bits for a 4-byte read), ignore writes and give no error.
- R10: Each valid request produces exactly one response, on the next cycle, and no response appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Size code: 0 = 1 B, 1 = 2 B, 2 = 4 B, 3 = 8 B |
| req_wdata | input | 64 | Write data |
| win_wr_en | input | 1 | Load the window register |
| win_wr_data | input | 64 | New window register value |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Bus error response |
| rsp_rdata | output | 64 | Read data |
| win_q | output | 64 | Current window register |

## Verification
Some rules are checked by assertions on every cycle:
- the one-cycle request-to-response pairing;
- error with zero data for byte and halfword sizes;
- error responses while the window is disabled;
- all-ones data from undefined views;
- bus-size flag drops only on a write that could have addressed the control view.

Other behaviour can only be shown by the bench's scenarios, because it depends on state built up over many accesses:
- window relocation and resizing;
- stride changes that move one cell to a new address;
- selective clearing of the flags;
- the cell-count bound;
- zero-extension of narrow cell writes.

// File: rtl/itc_pkg.sv
`timescale 1ns/1ps
package itc_pkg;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam logic [1:0] SZ_DBL  = 2'd3;

  localparam logic [3:0] VIEW_CTRL      = 4'd15;
  localparam logic [3:0] VIEW_CELL_LAST = 4'd5;

  localparam int ERR_BUS_BIT  = 2;
  localparam int GRAN_LSB     = 8;
  localparam int CNT_LSB      = 16;
  localparam int STRIDE_BASE  = 7;

  typedef enum logic [2:0] {
    K_MISS,
    K_BADSZ,
    K_CTRL,
    K_CELL,
    K_BADIDX,
    K_UNDEF
  } acc_kind_e;
endpackage

// File: rtl/itc_window_dec.sv
`timescale 1ns/1ps
module itc_window_dec #(
  parameter int          ADDR_W  = 52,
  parameter logic [63:0] RST_VAL = 64'h22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [63:0]       wr_data,
  input  logic [ADDR_W-1:0] addr,
  output logic [63:0]       win_q,
  output logic              hit,
  output logic [ADDR_W-1:0] offset
);
  logic [63:0]       base64;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W:0]   diff;
  logic [4:0]        size_log2;
  logic              below;
  logic              in_range;

  always_ff @(posedge clk) begin
    if (rst)        win_q <= RST_VAL;
    else if (wr_en) win_q <= wr_data;
  end

  always_comb begin
    base64    = {12'b0, win_q[47:13], 17'b0};
    base      = base64[ADDR_W-1:0];
    size_log2 = win_q[5:1];
    diff      = {1'b0, addr} - {1'b0, base};
    below     = diff[ADDR_W];
    offset    = diff[ADDR_W-1:0];
    in_range  = (offset >> size_log2) == '0;
    hit       = win_q[0] && !below && in_range;
  end
endmodule

// File: rtl/itc_addr_dec.sv
`timescale 1ns/1ps
module itc_addr_dec
  import itc_pkg::*;
#(
  parameter int ADDR_W    = 52,
  parameter int NUM_CELLS = 16,
  parameter int IDX_W     = 4
) (
  input  logic              hit,
  input  logic [ADDR_W-1:0] offset,
  input  logic [1:0]        size,
  input  logic [2:0]        gran,
  output acc_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);
  logic [3:0]        shift;
  logic [ADDR_W-1:0] full_idx;
  logic [3:0]        view;
  logic              idx_ok;

  always_comb begin
    shift    = 4'(STRIDE_BASE) + {1'b0, gran};
    full_idx = offset >> shift;
    idx      = full_idx[IDX_W-1:0];
    idx_ok   = full_idx < ADDR_W'(NUM_CELLS);
    view     = offset[6:3];
    if (!hit)                             kind = K_MISS;
    else if (size == SZ_BYTE || size == SZ_HALF) kind = K_BADSZ;
    else if (view == VIEW_CTRL)           kind = K_CTRL;
    else if (view <= VIEW_CELL_LAST)      kind = idx_ok ? K_CELL : K_BADIDX;
    else                                  kind = K_UNDEF;
  end
endmodule

// File: rtl/itc_cell_store.sv
`timescale 1ns/1ps
module itc_cell_store #(
  parameter int NUM_CELLS = 16,
  parameter int DATA_W    = 64,
  parameter int IDX_W     = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [NUM_CELLS];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/itc_ctrl_unit.sv
`timescale 1ns/1ps
module itc_ctrl_unit
  import itc_pkg::*;
#(
  parameter int          ADDR_W    = 52,
  parameter int          NUM_CELLS = 16,
  parameter logic [63:0] WIN_RST   = 64'h22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [63:0]       req_wdata,
  input  logic              win_wr_en,
  input  logic [63:0]       win_wr_data,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [63:0]       rsp_rdata,
  output logic [63:0]       win_q
);
  localparam int          IDX_W    = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1;
  localparam logic [63:0] CTRL_RST = 64'(NUM_CELLS) << CNT_LSB;

  logic              hit;
  logic [ADDR_W-1:0] offset;
  acc_kind_e         kind;
  logic [IDX_W-1:0]  idx;
  logic [63:0]       ctrl_q;
  logic [63:0]       cell_wdata;
  logic [63:0]       cell_rdata;
  logic              cell_we;
  logic              src_cell_q;
  logic              narrow_q;
  logic [63:0]       other_q;
  logic [63:0]       raw_rdata;

  itc_window_dec #(.ADDR_W(ADDR_W), .RST_VAL(WIN_RST)) u_win (
    .clk(clk), .rst(rst), .wr_en(win_wr_en), .wr_data(win_wr_data),
    .addr(req_addr), .win_q(win_q), .hit(hit), .offset(offset)
  );

  itc_addr_dec #(.ADDR_W(ADDR_W), .NUM_CELLS(NUM_CELLS), .IDX_W(IDX_W)) u_dec (
    .hit(hit), .offset(offset), .size(req_size),
    .gran(ctrl_q[GRAN_LSB+2:GRAN_LSB]), .kind(kind), .idx(idx)
  );

  assign cell_we    = req_valid && req_write && (kind == K_CELL);
  assign cell_wdata = (req_size == SZ_DBL) ? req_wdata : {32'b0, req_wdata[31:0]};

  itc_cell_store #(.NUM_CELLS(NUM_CELLS), .DATA_W(64), .IDX_W(IDX_W)) u_cells (
    .clk(clk), .we(cell_we), .addr(idx), .wdata(cell_wdata), .rdata(cell_rdata)
  );

  // Control word: sticky flags, granularity, fixed cell count
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST;
    end else if (req_valid) begin
      if (kind == K_BADSZ) begin
        ctrl_q[ERR_BUS_BIT] <= 1'b1;
      end else if (kind == K_CTRL && req_write) begin
        ctrl_q[2:0] <= ctrl_q[2:0] & ~req_wdata[2:0];
        ctrl_q[GRAN_LSB+2:GRAN_LSB] <= req_wdata[GRAN_LSB+2:GRAN_LSB];
      end
    end
  end

  // Response registers
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      src_cell_q <= 1'b0;
      narrow_q   <= 1'b0;
      other_q    <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_err    <= req_valid && (kind == K_MISS || kind == K_BADSZ || kind == K_BADIDX);
      src_cell_q <= req_valid && !req_write && (kind == K_CELL);
      narrow_q   <= req_size == SZ_WORD;
      if (req_valid && !req_write && kind == K_CTRL)       other_q <= ctrl_q;
      else if (req_valid && !req_write && kind == K_UNDEF) other_q <= '1;
      else                                                 other_q <= '0;
    end
  end

  assign raw_rdata = src_cell_q ? cell_rdata : other_q;
  assign rsp_rdata = narrow_q ? {32'b0, raw_rdata[31:0]} : raw_rdata;
endmodule

// File: rtl/itc_ctrl_unit_chk.sv
`timescale 1ns/1ps
module itc_ctrl_unit_chk #(
  parameter int ADDR_W = 52
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [63:0]       rsp_rdata,
  input logic [63:0]       win_q,
  input logic [63:0]       ctrl_q
);
  a_r10_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  a_r3_narrow_size_error: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size < 2'd2) |=> (rsp_err && rsp_rdata == 64'd0));
  a_r2_disabled_window_error: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !win_q[0]) |=> rsp_err);
  a_r9_undef_view_ones: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_size == 2'd3 &&
     req_addr[6:3] >= 4'd6 && req_addr[6:3] <= 4'd14)
    |=> (rsp_err || rsp_rdata == 64'hFFFF_FFFF_FFFF_FFFF));
  a_r5_flag_clears_only_by_write: assert property (@(posedge clk) disable iff (rst)
    $fell(ctrl_q[2]) |-> $past(req_valid && req_write && req_size >= 2'd2 &&
                               req_addr[6:3] == 4'd15));
endmodule

bind itc_ctrl_unit itc_ctrl_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_size(req_size), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .win_q(win_q), .ctrl_q(ctrl_q)
);

// File: tb/itc_ctrl_unit_bench.sv
`timescale 1ns/1ps
module itc_ctrl_unit_bench;
  localparam int ADDR_W = 52;
  localparam int NCELL  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr  = '0;
  logic [1:0]        req_size  = 2'd3;
  logic [63:0]       req_wdata = '0;
  logic              win_wr_en = 1'b0;
  logic [63:0]       win_wr_data = '0;
  logic              rsp_valid;
  logic              rsp_err;
  logic [63:0]       rsp_rdata;
  logic [63:0]       win_q;

  int nvec  = 0;
  int nfail = 0;
  bit done  = 1'b0;

  // reference model state
  logic [63:0] m_ctrl;
  logic [63:0] m_win;
  logic [63:0] m_cell [NCELL];
  logic        e_err;
  logic [63:0] e_rd;

  always #2.5 clk = ~clk;

  itc_ctrl_unit #(.ADDR_W(ADDR_W), .NUM_CELLS(NCELL)) u_itc_ctrl_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .win_wr_en(win_wr_en), .win_wr_data(win_wr_data), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .win_q(win_q)
  );

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic model(input bit wr, input logic [63:0] a, input logic [1:0] sz,
                       input logic [63:0] d);
    logic [63:0] base, off, idx, dv;
    logic [3:0]  view;
    bit hit;
    base = {12'b0, m_win[47:13], 17'b0};
    hit  = m_win[0] && a >= base && (a - base) < (64'd1 << m_win[5:1]);
    off  = a - base;
    view = off[6:3];
    idx  = off >> (7 + m_ctrl[10:8]);
    dv   = (sz == 2'd2) ? {32'b0, d[31:0]} : d;
    e_err = 1'b0;
    e_rd  = 64'd0;
    if (!hit) e_err = 1'b1;
    else if (sz < 2'd2) begin
      e_err = 1'b1;
      m_ctrl[2] = 1'b1;
    end else if (view == 4'd15) begin
      if (wr) begin
        m_ctrl[2:0]  = m_ctrl[2:0] & ~d[2:0];
        m_ctrl[10:8] = d[10:8];
      end else e_rd = m_ctrl;
    end else if (view <= 4'd5) begin
      if (idx >= 64'(NCELL)) e_err = 1'b1;
      else if (wr) m_cell[idx] = dv;
      else e_rd = m_cell[idx];
    end else if (!wr) e_rd = '1;
    if (sz == 2'd2) e_rd = {32'b0, e_rd[31:0]};
  endtask

  task automatic op(input bit wr, input logic [63:0] a, input logic [1:0] sz,
                    input logic [63:0] d, input string tag);
    @(negedge clk);
    chk({tag, " R10 idle"}, {63'd0, rsp_valid}, 64'd0);
    req_valid = 1'b1; req_write = wr; req_addr = a[ADDR_W-1:0];
    req_size = sz; req_wdata = d;
    model(wr, a, sz, d);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R10 valid"}, {63'd0, rsp_valid}, 64'd1);
    chk({tag, " err"}, {63'd0, rsp_err}, {63'd0, e_err});
    chk({tag, " rdata"}, rsp_rdata, e_rd);
  endtask

  task automatic set_win(input logic [63:0] v, input string tag);
    @(negedge clk);
    win_wr_en = 1'b1; win_wr_data = v; m_win = v;
    @(negedge clk);
    win_wr_en = 1'b0;
    chk({tag, " window"}, win_q, m_win);
  endtask

  localparam logic [63:0] B = 64'h20000;

  initial begin
    m_ctrl = 64'(NCELL) << 16;
    m_win  = 64'h22;
    for (int i = 0; i < NCELL; i++) m_cell[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 window reset", win_q, 64'h22);
    chk("R1 no response", {63'd0, rsp_valid}, 64'd0);
    op(0, B + 64'h78, 2'd3, 0, "R2 disabled window");
    set_win(64'h2023, "R2 enable");
    op(0, B + 64'h78, 2'd3, 0, "R1 R4 ctrl reset value");
    op(1, B + 64'h00, 2'd0, 64'hAA, "R3 byte write");
    op(0, B + 64'h08, 2'd1, 0, "R3 half read");
    op(0, B + 64'h78, 2'd3, 0, "R3 flag set");
    op(1, B + 64'h78, 2'd3, 64'h300, "R5 keep flag");
    op(0, B + 64'h78, 2'd3, 0, "R5 gran 3");
    op(1, B + 64'h78, 2'd2, 64'h004, "R5 clear flag gran 0");
    op(0, B + 64'h78, 2'd3, 0, "R5 readback");
    for (int i = 0; i < 6; i++)
      op(1, B + 64'(i) * 128 + 64'(i) * 8, 2'd3, 64'hC0DE_0000_0000_0000 | 64'(i), "R6 R8 cell write");
    for (int i = 0; i < 6; i++)
      op(0, B + 64'(i) * 128 + 64'(5 - i) * 8, 2'd3, 0, "R6 R8 cell read");
    op(1, B + 64'd15 * 128, 2'd2, 64'hFFFF_FFFF_1234_5678, "R8 narrow write");
    op(0, B + 64'd15 * 128, 2'd3, 0, "R8 narrow readback");
    op(0, B + 64'd1 * 128, 2'd2, 0, "R8 narrow read");
    op(1, B + 64'd16 * 128, 2'd3, 64'h1, "R7 index beyond");
    op(0, B + 64'd20 * 128, 2'd3, 0, "R7 index beyond read");
    op(0, B + 64'h38, 2'd3, 0, "R9 view 7 read");
    op(0, B + 64'h70, 2'd2, 0, "R9 view 14 narrow");
    op(1, B + 64'h48, 2'd3, 64'h5555, "R9 view 9 write");
    op(0, B + 64'h00, 2'd3, 0, "R9 cell 0 unchanged");
    op(1, B + 64'h78, 2'd3, 64'h300, "R6 gran 3");
    op(0, B + 64'd2 * 1024, 2'd3, 0, "R6 stride 1024 cell 2");
    op(1, B + 64'd3 * 1024 + 64'h10, 2'd3, 64'h77, "R6 stride write cell 3");
    op(0, B + 64'd3 * 128, 2'd3, 0, "R6 cell 3 at old stride");
    op(1, B + 64'h78, 2'd3, 64'h000, "R6 gran 0");
    op(0, B + 64'd3 * 128, 2'd3, 0, "R6 cell 3 gran 0");
    op(0, B - 8, 2'd3, 0, "R2 below base");
    op(1, B + 64'h20000, 2'd3, 64'h99, "R2 above limit");
    op(1, B + 64'h20000, 2'd0, 64'h99, "R2 narrow outside no flag");
    op(0, B + 64'h78, 2'd3, 0, "R2 flag untouched");
    set_win(64'h2000 | (64'd13 << 1) | 64'd1, "R2 resize");
    op(0, B + 64'h2000, 2'd3, 0, "R2 beyond small window");
    op(0, B + 64'h100, 2'd3, 0, "R2 inside small window");
    set_win(64'h4000 | (64'd17 << 1) | 64'd1, "R2 relocate");
    op(0, 64'h40000 + 64'd4 * 128, 2'd3, 0, "R2 relocated cell 4");
    op(0, B + 64'd4 * 128, 2'd3, 0, "R2 old base miss");
    set_win(64'h4000 | (64'd17 << 1), "R2 disable");
    op(0, 64'h40000, 2'd3, 0, "R2 disabled");
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1'b1;
      nfail++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule